// File: doc/BRIEF.md
# Master-Clock Ratio Detector with Slip Resynchronisation

This block sits on the master clock of an audio converter and watches the external frame clock, whose period is one sample. It counts master-clock cycles between successive rising frame-clock edges and sorts the count into one of three supported ratios: 256, 384 or 512 master clocks per sample. A count that matches no supported ratio is treated as a broken clock setup. Lock is withdrawn and the block asks the output stage to mute.

Once locked, the block runs its own frame counter from the master clock and emits one strobe per internal frame. The datapath paces itself from that strobe, so jitter on the external frame clock does not reach it. The block adds up how far each external period departs from the nominal ratio. When that running slip goes past half a nominal frame, the block puts the internal counter back in line with the external edge. It also gives the datapath a one-cycle hint to either repeat the previous sample or drop the next one, so the output has no hard restart.

The block has no data stream of its own. All of its pins are plain control and status levels or pulses, and there is no back-pressure anywhere.

Top module: `clkratio_resync`

## Requirements
- R1: A measured period P is classed as code 1 when P is in 256±8, code 2 when P is in 384±8, and code 3 when P is in 512±8; all bounds are inclusive. Any other P is class 0. While locked, `ratio_code` shows the locked class. While unlocked, it shows 0.
- R2: The frame clock is sampled through two flops before its rising edges are detected. The first edge after reset only starts a measurement. Lock is gained on the cycle after the second of two consecutive measurements that fall in the same nonzero class.
- R3: `mute_req` is high whenever the block is not locked. While locked, a measurement of class 0, or of a class other than the locked one, drops lock on the cycle after that edge, and `ratio_code` returns to 0 at the same time.
- R4: If the detected edges stop and the count since the last edge exceeds 520 (512+8), lock is dropped without waiting for another edge.
- R5: While locked, `frame_strobe` is high for one cycle every N cycles, where N is the nominal ratio of the locked class. The first strobe comes N cycles after the edge that set the alignment, which is either the lock edge or a resync edge.
- R6: Each in-class measurement adds P−N to a signed slip sum. If the sum rises above +N/2, `repeat_pulse` is high for one cycle on the cycle after that edge. The sum is cleared and the internal counter is realigned to that edge.
- R7: If the slip sum falls below −N/2, `drop_pulse` is high for one cycle instead, with the same clear and realign. The two pulses are never high together.
- R8: A steady period error within tolerance causes resyncs only once every many frames, never on every frame. Jitter that averages to zero causes no resync at all.
- R9: During reset, `ratio_code` and `locked` are 0, `mute_req` is 1, and `frame_strobe`, `repeat_pulse` and `drop_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | External frame (sample-rate) clock, asynchronous |
| ratio_code | output | 2 | Locked ratio class: 0 none, 1 = 256, 2 = 384, 3 = 512 |
| locked | output | 1 | Ratio detected and stable |
| mute_req | output | 1 | Request to mute the output stage |
| frame_strobe | output | 1 | One pulse per internal frame |
| repeat_pulse | output | 1 | Datapath should repeat the previous sample |
| drop_pulse | output | 1 | Datapath should drop the next sample |

## Verification
The bench builds the block with its default parameters: ratios 256, 384 and 512, a tolerance of 8, and a two-stage synchroniser. With these values the periods at the edges of each tolerance window (248, 264, 520, 521) can be tried in a few frames. They also put the ±N/2 slip thresholds close enough that a steady 4-cycle error triggers a resync roughly every 33 frames. Several such resyncs, in both directions, then fit into one short run, together with the timeout on a stopped frame clock and a switch between ratios.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [1:0] {
    RC_NONE = 2'd0,
    RC_LOW  = 2'd1,
    RC_MID  = 2'd2,
    RC_HIGH = 2'd3
  } ratio_e;
endpackage

// File: rtl/cr_edge_sync.sv
module cr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;

  // R2: a detected edge lasts exactly one cycle
  a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/cr_period_meter.sv
module cr_period_meter
  import cr_pkg::*;
#(
  parameter int R_LO  = 256,
  parameter int R_MID = 384,
  parameter int R_HI  = 512,
  parameter int TOL   = 8,
  parameter int CW    = 10,
  parameter int NW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  output ratio_e        ratio_q,
  output logic          locked_q,
  output logic [CW-1:0] period,
  output logic          in_step,
  output logic [NW-1:0] nominal
);
  localparam int LIMIT = R_HI + TOL;
  localparam logic [CW-1:0] LIMIT_B = CW'(LIMIT);

  logic [CW-1:0] per_cnt;
  logic          seen_q;
  ratio_e        prev_q;
  ratio_e        cls;
  logic [2:0]    hit;

  for (genvar g = 0; g < 3; g++) begin : g_cls
    localparam int RV = (g == 0) ? R_LO : ((g == 1) ? R_MID : R_HI);
    localparam logic [CW-1:0] LO_B = CW'(RV - TOL);
    localparam logic [CW-1:0] HI_B = CW'(RV + TOL);
    assign hit[g] = (per_cnt >= LO_B) && (per_cnt <= HI_B);
  end

  always_comb begin
    cls = RC_NONE;
    if (hit[0])      cls = RC_LOW;
    else if (hit[1]) cls = RC_MID;
    else if (hit[2]) cls = RC_HIGH;
  end

  always_comb begin
    case (ratio_q)
      RC_MID:  nominal = NW'(R_MID);
      RC_HIGH: nominal = NW'(R_HI);
      default: nominal = NW'(R_LO);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt  <= '0;
      seen_q   <= 1'b0;
      prev_q   <= RC_NONE;
      ratio_q  <= RC_NONE;
      locked_q <= 1'b0;
    end else begin
      if (rise) begin
        per_cnt <= CW'(1);
        seen_q  <= 1'b1;
      end else if (per_cnt != '1) begin
        per_cnt <= per_cnt + CW'(1);
      end

      if (rise && seen_q) begin
        prev_q <= cls;
        if (locked_q) begin
          if (cls != ratio_q) begin
            locked_q <= 1'b0;
            ratio_q  <= RC_NONE;
          end
        end else if (cls != RC_NONE && cls == prev_q) begin
          locked_q <= 1'b1;
          ratio_q  <= cls;
        end
      end else if (!rise && seen_q && per_cnt > LIMIT_B) begin
        locked_q <= 1'b0;
        ratio_q  <= RC_NONE;
        prev_q   <= RC_NONE;
      end
    end
  end

  assign period  = per_cnt;
  assign in_step = rise && seen_q && locked_q && (cls == ratio_q);

  // R1: a locked block always reports a real ratio
  a_r1_locked_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> ratio_q != RC_NONE);
  // R2: lock is only gained at a detected edge
  a_r2_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(rise));
  // R3: an unclassifiable measurement leaves the block unlocked
  a_r3_bad_measure_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && seen_q && cls == RC_NONE) |=> !locked_q);
  // R4: a missing edge beyond the limit withdraws lock
  a_r4_timeout_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !rise && per_cnt > LIMIT_B) |=> !locked_q);
endmodule

// File: rtl/cr_phase_tracker.sv
module cr_phase_tracker #(
  parameter int CW = 10,
  parameter int NW = 10,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          locked,
  input  logic          in_step,
  input  logic [CW-1:0] period,
  input  logic [NW-1:0] nominal,
  output logic          strobe,
  output logic          repeat_q,
  output logic          drop_q
);
  logic signed [AW-1:0] acc_q, acc_nx, diff, half;
  logic [NW-1:0]        fcnt_q;
  logic                 over, under;

  assign diff   = $signed({{(AW-CW){1'b0}}, period}) - $signed({{(AW-NW){1'b0}}, nominal});
  assign half   = $signed({{(AW-NW+1){1'b0}}, nominal[NW-1:1]});
  assign acc_nx = acc_q + diff;
  assign over   = acc_nx > half;
  assign under  = acc_nx < -half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      fcnt_q   <= '0;
      repeat_q <= 1'b0;
      drop_q   <= 1'b0;
    end else if (!locked) begin
      acc_q    <= '0;
      fcnt_q   <= '0;
      repeat_q <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      repeat_q <= in_step && over;
      drop_q   <= in_step && under;
      if (in_step && (over || under)) begin
        acc_q  <= '0;
        fcnt_q <= '0;
      end else begin
        if (in_step) acc_q <= acc_nx;
        fcnt_q <= (fcnt_q == nominal - NW'(1)) ? '0 : fcnt_q + NW'(1);
      end
    end
  end

  assign strobe = locked && (fcnt_q == nominal - NW'(1));

  // R5: the internal frame position stays inside the nominal frame
  a_r5_fcnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> fcnt_q < nominal);
  // R6: slip never sits beyond half a frame after an update
  a_r6_acc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= half) && (acc_q >= -half));
  // R6: a resync pulse follows an in-step edge
  a_r6_pulse_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (repeat_q || drop_q) |-> $past(in_step));
  // R7: repeat and drop are exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(repeat_q && drop_q));
endmodule

// File: rtl/clkratio_resync.sv
module clkratio_resync
  import cr_pkg::*;
#(
  parameter int R_LO   = 256,
  parameter int R_MID  = 384,
  parameter int R_HI   = 512,
  parameter int TOL    = 8,
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_clk,
  output logic [1:0] ratio_code,
  output logic       locked,
  output logic       mute_req,
  output logic       frame_strobe,
  output logic       repeat_pulse,
  output logic       drop_pulse
);
  localparam int CW = $clog2(R_HI + TOL + 2);
  localparam int NW = $clog2(R_HI + 1);
  localparam int AW = CW + 2;

  logic          rise, in_step, locked_w;
  logic [CW-1:0] period;
  logic [NW-1:0] nominal;
  ratio_e        ratio_w;

  cr_edge_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(frame_clk), .rise(rise)
  );

  cr_period_meter #(
    .R_LO(R_LO), .R_MID(R_MID), .R_HI(R_HI), .TOL(TOL), .CW(CW), .NW(NW)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .rise(rise), .ratio_q(ratio_w),
    .locked_q(locked_w), .period(period), .in_step(in_step), .nominal(nominal)
  );

  cr_phase_tracker #(.CW(CW), .NW(NW), .AW(AW)) u_track (
    .clk(clk), .rst_n(rst_n), .locked(locked_w), .in_step(in_step),
    .period(period), .nominal(nominal), .strobe(frame_strobe),
    .repeat_q(repeat_pulse), .drop_q(drop_pulse)
  );

  assign ratio_code = ratio_w;
  assign locked     = locked_w;
  assign mute_req   = ~locked_w;
endmodule

// File: tb/test_clkratio_resync.sv
module test_clkratio_resync;
  localparam int CLK_PERIOD = 10;
  localparam int TOL        = 8;
  localparam int LIMIT      = 512 + TOL;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0, rst_n = 1'b0, frame_clk = 1'b0;
  logic [1:0] ratio_code;
  logic locked, mute_req, frame_strobe, repeat_pulse, drop_pulse;

  int checks = 0, errors = 0, wd = 0, n_rep = 0, n_drop = 0;
  bit done = 1'b0;

  // model state
  int  cyc, m_last, m_prev, m_ratio, m_acc, m_align;
  bit  m_seen, m_lk, m_rep, m_drop, m_strobe, m_s1, m_s2, m_s3;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkratio_resync i_clkratio_resync (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .ratio_code(ratio_code),
    .locked(locked), .mute_req(mute_req), .frame_strobe(frame_strobe),
    .repeat_pulse(repeat_pulse), .drop_pulse(drop_pulse)
  );

  function automatic int cls_of(int p);
    if (p >= 256 - TOL && p <= 256 + TOL) return 1;
    if (p >= 384 - TOL && p <= 384 + TOL) return 2;
    if (p >= 512 - TOL && p <= 512 + TOL) return 3;
    return 0;
  endfunction

  function automatic int nom_of(int r);
    return (r == 2) ? 384 : (r == 3) ? 512 : 256;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference, advanced once per clock
  always @(posedge clk) begin
    int per, cls, nom, nacc;
    bit e, lk_old, tick;
    if (!rst_n) begin
      cyc = 0; m_last = 0; m_prev = 0; m_ratio = 0; m_acc = 0; m_align = 0;
      m_seen = 0; m_lk = 0; m_rep = 0; m_drop = 0; m_strobe = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      cyc++;
      e = m_s2 && !m_s3;
      lk_old = m_lk;
      nom = nom_of(m_ratio);
      per = cyc - m_last;
      tick = 0; m_rep = 0; m_drop = 0;
      if (e && m_seen) begin
        cls = cls_of(per);
        tick = m_lk && (cls == m_ratio);
        if (m_lk) begin
          if (cls != m_ratio) begin m_lk = 0; m_ratio = 0; end
        end else if (cls != 0 && cls == m_prev) begin
          m_lk = 1; m_ratio = cls;
        end
        m_prev = cls;
      end else if (!e && m_seen && per > LIMIT) begin
        m_lk = 0; m_ratio = 0; m_prev = 0;
      end
      if (e) begin m_seen = 1; m_last = cyc; end
      if (!lk_old) begin
        m_acc = 0; m_align = cyc;
      end else if (tick) begin
        nacc = m_acc + per - nom;
        if (nacc > nom / 2) begin m_rep = 1; m_acc = 0; m_align = cyc; end
        else if (nacc < -(nom / 2)) begin m_drop = 1; m_acc = 0; m_align = cyc; end
        else m_acc = nacc;
      end
      m_strobe = m_lk && (((cyc + 1 - m_align) % nom_of(m_ratio)) == 0);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = frame_clk;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(ratio_code == 2'(m_ratio), "R1 ratio_code", ratio_code, m_ratio);
      chk(locked == m_lk, "R2 locked", locked, m_lk);
      chk(mute_req == !m_lk, "R3 mute_req", mute_req, !m_lk);
      chk(frame_strobe == m_strobe, "R5 frame_strobe", frame_strobe, m_strobe);
      chk(repeat_pulse == m_rep, "R6 repeat_pulse", repeat_pulse, m_rep);
      chk(drop_pulse == m_drop, "R7 drop_pulse", drop_pulse, m_drop);
      if (repeat_pulse) n_rep++;
      if (drop_pulse) n_drop++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > WD_CYCLES && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", wd, WD_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic frames(input int per, input int n);
    for (int i = 0; i < n; i++) begin
      frame_clk = 1'b1;
      repeat (per / 2) @(negedge clk);
      frame_clk = 1'b0;
      repeat (per - per / 2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset values
    chk(ratio_code == 2'd0 && !locked, "R9 reset code/lock", {ratio_code, locked}, 0);
    chk(mute_req && !frame_strobe && !repeat_pulse && !drop_pulse,
        "R9 reset mute/pulses", {mute_req, frame_strobe, repeat_pulse, drop_pulse}, 8);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    frames(256, 6);
    chk(locked && ratio_code == 2'd1, "R2 lock at 256", ratio_code, 1);
    frames(384, 6);
    chk(locked && ratio_code == 2'd2, "R1 switch to 384", ratio_code, 2);
    frames(512, 5);
    frames(520, 3);
    chk(locked && ratio_code == 2'd3, "R1 upper bound 520", ratio_code, 3);
    frames(521, 3);
    chk(!locked && mute_req, "R3 521 rejected", locked, 0);
    frames(248, 4);
    chk(locked && ratio_code == 2'd1, "R1 lower bound 248", ratio_code, 1);

    n_rep = 0; n_drop = 0;
    frames(252, 80);
    chk(n_drop >= 1 && n_drop <= 5, "R8 steady -4 occasional drops", n_drop, 2);
    chk(n_rep == 0, "R7 no repeat on fast source", n_rep, 0);

    n_rep = 0; n_drop = 0;
    frames(260, 80);
    chk(n_rep >= 1 && n_rep <= 5, "R6 steady +4 occasional repeats", n_rep, 2);
    chk(n_drop == 0, "R6 no drop on slow source", n_drop, 0);

    n_rep = 0; n_drop = 0;
    for (int j = 0; j < 30; j++) begin
      frames(254, 1);
      frames(258, 1);
    end
    chk(n_rep == 0 && n_drop == 0, "R8 zero-mean jitter no resync", n_rep + n_drop, 0);
    chk(locked, "R2 lock kept under jitter", locked, 1);

    frame_clk = 1'b0;
    repeat (600) @(negedge clk);
    chk(!locked && mute_req, "R4 stopped frame clock", locked, 0);

    frames(256, 4);
    frames(270, 5);
    chk(!locked && ratio_code == 2'd0, "R3 out of tolerance", ratio_code, 0);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule